// File: doc/BRIEF.md
# Matrix Keypad Numeric Entry Controller

This block reads a 4x4 matrix keypad through one 8-bit port and turns the key presses into a numeric entry with a unit. The keypad port is modelled as an open-drain drive vector (`port_drv`) and a read-back vector (`port_in`). When no key is active, the controller drives the upper nibble high and the lower nibble low. A pressed key pulls one upper line and one lower line low. The key is located by line reversal. The first read gives the upper nibble. The sampled byte is then OR-ed with 0x0F and driven back, so the second read gives the lower nibble. The idle drive is restored one cycle later.

The scan engine only moves on a slow `poll_tick`. It has four states:
- `ST_WAIT_PRESS` goes to `ST_CHECK_PRESS` when a sample differs from idle.
- `ST_CHECK_PRESS` goes to `ST_WAIT_RELEASE` when a second sample matches the first. On that transition it performs the reversal read. If the samples differ, it returns to `ST_WAIT_PRESS`.
- `ST_WAIT_RELEASE` goes to `ST_CHECK_RELEASE` when the port reads idle.
- `ST_CHECK_RELEASE` returns to `ST_WAIT_PRESS` when idle is read a second time, and only then is the key acted on. If the key is seen again, it goes back to `ST_WAIT_RELEASE`.

The captured code is decoded to a key index. Digits build a decimal value, three keys choose Hz, kHz or MHz, and an enter key presents the scaled and range-limited value with a single-cycle strobe.

Top module: `kpad_entry_ctrl`

## Requirements
- R1: After reset, `port_drv` is 0xF0, `value` is 0, `unit_sel` is 0 (Hz), and `key_valid` and `result_valid` are low.
- R2: The reported index follows the code {upper nibble from the idle-drive read, lower nibble from the reversed read}. Indexes 0 to 15 map to codes BB, E7, EB, ED, EE, D7, DB, DD, DE, B7, BD, 7E, 7D, 7B, 77, BE (hex). `key_valid` is high for one cycle with `key_idx` holding the index. The drive returns to 0xF0 one cycle after the reversal read.
- R3: A press counts only when two successive tick samples are equal. On a mismatch the controller returns to waiting for a press, and no key is reported.
- R4: A key is reported only after two successive tick samples read idle. Holding a key, or a single idle sample followed by a renewed press, reports nothing.
- R5: Without `poll_tick`, port activity neither changes the drive nor reports a key.
- R6: Digit keys (index 0 to 9) set value = value*10 + digit. At most six digits are taken since the last enter. Further digits still strobe `key_valid` but leave `value` unchanged.
- R7: The decimal point key (index 10) and the auxiliary key (index 15) strobe `key_valid` and change neither `value` nor `unit_sel`.
- R8: Index 12 sets `unit_sel` to 0 (multiplier 1). Index 13 sets it to 1 (multiplier 1000). Index 14 sets it to 2 (multiplier 1000000).
- R9: Enter (index 11) drives `result` = value * multiplier, or 0 if that product is above 160000000, with `result_valid` high for one cycle. In the same cycle it clears `value` and the digit count, and it keeps the unit.
- R10: A code that is not in the table, such as two keys held on one row, produces no `key_valid` and no change to `value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_tick | input | 1 | One-cycle tick from the slow poll timer |
| port_in | input | 8 | Keypad port read-back |
| port_drv | output | 8 | Keypad port drive pattern |
| key_idx | output | 4 | Index of the last reported key |
| key_valid | output | 1 | One-cycle strobe per reported key |
| value | output | VAL_W (20) | Accumulated decimal entry |
| unit_sel | output | 2 | Selected unit: 0 Hz, 1 kHz, 2 MHz |
| result | output | RES_W (28) | Scaled value presented on enter |
| result_valid | output | 1 | One-cycle strobe with `result` |

## Verification
The bench builds the block with its defaults, MAX_DIGITS = 6 and LIMIT = 160000000. With these values the digit cap is reached after a seven-digit entry, and the MHz and kHz units let short entries land exactly on the limit, just above it and far above it. A modelled wired-AND keypad lets the bench create bounce, held keys, re-presses and two-key codes that are not in the table. Random key sequences are then compared against a bench model of the value, the unit and the result.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_PRESS    = 2'd0,
        ST_CHECK_PRESS   = 2'd1,
        ST_WAIT_RELEASE  = 2'd2,
        ST_CHECK_RELEASE = 2'd3
    } scan_state_t;

    typedef enum logic [1:0] {
        UNIT_HZ  = 2'd0,
        UNIT_KHZ = 2'd1,
        UNIT_MHZ = 2'd2
    } unit_t;

    localparam logic [7:0] PORT_IDLE  = 8'hF0;
    localparam logic [7:0] LOW_SENSE  = 8'h0F;

    localparam logic [3:0] KEY_LAST_DIGIT = 4'd9;
    localparam logic [3:0] KEY_POINT      = 4'd10;
    localparam logic [3:0] KEY_ENTER      = 4'd11;
    localparam logic [3:0] KEY_HZ         = 4'd12;
    localparam logic [3:0] KEY_KHZ        = 4'd13;
    localparam logic [3:0] KEY_MHZ        = 4'd14;
    localparam logic [3:0] KEY_AUX        = 4'd15;

    localparam int MULT_W = 20;

    // key index -> code seen after line reversal
    function automatic logic [7:0] key_code(input logic [3:0] idx);
        logic [7:0] c;
        case (idx)
            4'd0:  c = 8'hBB;
            4'd1:  c = 8'hE7;
            4'd2:  c = 8'hEB;
            4'd3:  c = 8'hED;
            4'd4:  c = 8'hEE;
            4'd5:  c = 8'hD7;
            4'd6:  c = 8'hDB;
            4'd7:  c = 8'hDD;
            4'd8:  c = 8'hDE;
            4'd9:  c = 8'hB7;
            4'd10: c = 8'hBD;
            4'd11: c = 8'h7E;
            4'd12: c = 8'h7D;
            4'd13: c = 8'h7B;
            4'd14: c = 8'h77;
            default: c = 8'hBE;
        endcase
        return c;
    endfunction

    function automatic logic [MULT_W-1:0] unit_mult(input unit_t u);
        logic [MULT_W-1:0] m;
        unique case (u)
            UNIT_KHZ: m = MULT_W'(1000);
            UNIT_MHZ: m = MULT_W'(1000000);
            default:  m = MULT_W'(1);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/kpad_scan.sv
module kpad_scan
    import kpad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       poll_tick,
    input  logic [7:0] port_in,
    output logic [7:0] port_drv,
    output logic [7:0] code,
    output logic       code_stb
);

    scan_state_t state_q, state_d;
    logic [7:0]  first_q;
    logic [7:0]  code_q;
    logic [7:0]  drv_q;
    logic        rev_pend_q;
    logic        stb_q;
    logic        step;
    logic        port_idle;

    assign step      = poll_tick && !rev_pend_q;
    assign port_idle = (port_in == PORT_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                ST_WAIT_PRESS:    if (!port_idle) state_d = ST_CHECK_PRESS;
                ST_CHECK_PRESS:   state_d = (port_in == first_q) ? ST_WAIT_RELEASE : ST_WAIT_PRESS;
                ST_WAIT_RELEASE:  if (port_idle) state_d = ST_CHECK_RELEASE;
                ST_CHECK_RELEASE: state_d = port_idle ? ST_WAIT_PRESS : ST_WAIT_RELEASE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_PRESS;
        else        state_q <= state_d;
    end

    // outputs and sampled data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q    <= '0;
            code_q     <= '0;
            drv_q      <= PORT_IDLE;
            rev_pend_q <= 1'b0;
            stb_q      <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (rev_pend_q) begin
                code_q     <= port_in;
                drv_q      <= PORT_IDLE;
                rev_pend_q <= 1'b0;
            end
            if (step) begin
                if (state_q == ST_WAIT_PRESS && !port_idle)
                    first_q <= port_in;
                if (state_q == ST_CHECK_PRESS && port_in == first_q) begin
                    drv_q      <= first_q | LOW_SENSE;
                    rev_pend_q <= 1'b1;
                end
                if (state_q == ST_CHECK_RELEASE && port_idle)
                    stb_q <= 1'b1;
            end
        end
    end

    assign port_drv = drv_q;
    assign code     = code_q;
    assign code_stb = stb_q;

    assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_tick |=> $stable(state_q));

    assert_drive_restored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rev_pend_q |=> (port_drv == PORT_IDLE));

    assert_report_after_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_stb |-> ($past(state_q) == ST_CHECK_RELEASE && state_q == ST_WAIT_PRESS));

    assert_reverse_after_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rev_pend_q) |-> (state_q == ST_WAIT_RELEASE && $past(state_q) == ST_CHECK_PRESS));

endmodule

// File: rtl/kpad_decode.sv
module kpad_decode
    import kpad_pkg::*;
#(
    parameter int KEYS = 16
) (
    input  logic [7:0] code,
    output logic       hit,
    output logic [3:0] idx
);

    logic [KEYS-1:0] match;

    for (genvar gi = 0; gi < KEYS; gi++) begin : g_match
        assign match[gi] = (code == key_code(4'(gi)));
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < KEYS; i++)
            if (match[i]) idx = 4'(i);
    end

    assign hit = |match;

    always_comb begin
        assert_single_match_R2: assert ($onehot0(match))
            else $error("key table gives more than one index");
    end

endmodule

// File: rtl/kpad_accum.sv
module kpad_accum
    import kpad_pkg::*;
#(
    parameter int MAX_DIGITS = 6,
    parameter int LIMIT      = 160000000,
    parameter int VAL_W      = 20,
    parameter int RES_W      = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_stb,
    input  logic [3:0]       key_in,
    output logic [3:0]       key_idx,
    output logic             key_valid,
    output logic [VAL_W-1:0] value,
    output logic [1:0]       unit_sel,
    output logic [RES_W-1:0] result,
    output logic             result_valid
);

    localparam int CNT_W  = $clog2(MAX_DIGITS + 1);
    localparam int PROD_W = VAL_W + MULT_W;

    logic [VAL_W-1:0]  value_q;
    logic [CNT_W-1:0]  cnt_q;
    unit_t             unit_q;
    logic [3:0]        idx_q;
    logic              kv_q;
    logic [RES_W-1:0]  res_q;
    logic              rv_q;
    logic [VAL_W-1:0]  digit_next;
    logic [PROD_W-1:0] product;
    logic [RES_W-1:0]  res_d;

    always_comb begin
        digit_next = VAL_W'(({4'd0, value_q} * (VAL_W+4)'(10)) + (VAL_W+4)'(key_in));
        product    = PROD_W'(value_q) * PROD_W'(unit_mult(unit_q));
        res_d      = (product > PROD_W'(LIMIT)) ? '0 : RES_W'(product);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            cnt_q   <= '0;
            unit_q  <= UNIT_HZ;
            idx_q   <= '0;
            kv_q    <= 1'b0;
            res_q   <= '0;
            rv_q    <= 1'b0;
        end else begin
            kv_q <= key_stb;
            rv_q <= 1'b0;
            if (key_stb) begin
                idx_q <= key_in;
                if (key_in <= KEY_LAST_DIGIT) begin
                    if (cnt_q < CNT_W'(MAX_DIGITS)) begin
                        value_q <= digit_next;
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end else begin
                    unique case (key_in)
                        KEY_ENTER: begin
                            res_q   <= res_d;
                            rv_q    <= 1'b1;
                            value_q <= '0;
                            cnt_q   <= '0;
                        end
                        KEY_HZ:  unit_q <= UNIT_HZ;
                        KEY_KHZ: unit_q <= UNIT_KHZ;
                        KEY_MHZ: unit_q <= UNIT_MHZ;
                        default: ; // point and auxiliary: no data effect
                    endcase
                end
            end
        end
    end

    assign key_idx      = idx_q;
    assign key_valid    = kv_q;
    assign value        = value_q;
    assign unit_sel     = unit_q;
    assign result       = res_q;
    assign result_valid = rv_q;

    assert_digit_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_DIGITS));

    assert_value_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && idx_q <= KEY_LAST_DIGIT && $past(cnt_q) == CNT_W'(MAX_DIGITS)) |-> $stable(value_q));

    assert_result_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (result <= RES_W'(LIMIT)));

    assert_clear_on_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (value_q == '0 && cnt_q == '0));

    assert_single_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_point_aux_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && (idx_q == KEY_POINT || idx_q == KEY_AUX)) |-> ($stable(value_q) && $stable(unit_q)));

endmodule

// File: rtl/kpad_entry_ctrl.sv
module kpad_entry_ctrl
    import kpad_pkg::*;
#(
    parameter int MAX_DIGITS = 6,
    parameter int LIMIT      = 160000000,
    parameter int VAL_W      = $clog2(10 ** MAX_DIGITS),
    parameter int RES_W      = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_tick,
    input  logic [7:0]       port_in,
    output logic [7:0]       port_drv,
    output logic [3:0]       key_idx,
    output logic             key_valid,
    output logic [VAL_W-1:0] value,
    output logic [1:0]       unit_sel,
    output logic [RES_W-1:0] result,
    output logic             result_valid
);

    logic [7:0] code;
    logic       code_stb;
    logic       hit;
    logic [3:0] dec_idx;

    kpad_scan u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .poll_tick(poll_tick),
        .port_in  (port_in),
        .port_drv (port_drv),
        .code     (code),
        .code_stb (code_stb)
    );

    kpad_decode u_decode (
        .code(code),
        .hit (hit),
        .idx (dec_idx)
    );

    kpad_accum #(
        .MAX_DIGITS(MAX_DIGITS),
        .LIMIT     (LIMIT),
        .VAL_W     (VAL_W),
        .RES_W     (RES_W)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_stb     (code_stb && hit),
        .key_in      (dec_idx),
        .key_idx     (key_idx),
        .key_valid   (key_valid),
        .value       (value),
        .unit_sel    (unit_sel),
        .result      (result),
        .result_valid(result_valid)
    );

    assert_unknown_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (code_stb && !hit) |=> (!key_valid && $stable(value)));

endmodule

// File: tb/kpad_entry_ctrl_bench.sv
module kpad_entry_ctrl_bench;

    localparam int LIMIT = 160000000;
    localparam int MAXD  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_tick = 1'b0;
    logic [7:0]  port_in;
    logic [7:0]  port_drv;
    logic [3:0]  key_idx;
    logic        key_valid;
    logic [19:0] value;
    logic [1:0]  unit_sel;
    logic [27:0] result;
    logic        result_valid;

    logic [15:0] pressed = '0;   // bit r*4+c: upper line r tied to lower line c

    int n_chk = 0, n_fail = 0;
    int key_cnt = 0, res_cnt = 0;
    int last_idx = 0;
    longint last_res = 0;
    bit done = 0;

    // bench model
    longint m_val = 0;
    int     m_cnt = 0;
    int     m_unit = 0;
    longint m_res = 0;

    always #5 clk = ~clk;

    kpad_entry_ctrl u_kpad_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .poll_tick(poll_tick),
        .port_in(port_in), .port_drv(port_drv),
        .key_idx(key_idx), .key_valid(key_valid),
        .value(value), .unit_sel(unit_sel),
        .result(result), .result_valid(result_valid)
    );

    // wired-AND keypad model
    always_comb begin
        port_in = port_drv;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (pressed[r*4+c]) begin
                    if (!port_drv[c])   port_in[4+r] = 1'b0;
                    if (!port_drv[4+r]) port_in[c]   = 1'b0;
                end
    end

    always @(negedge clk) begin
        if (key_valid)    begin key_cnt++; last_idx = int'(key_idx); end
        if (result_valid) begin res_cnt++; last_res = longint'(result); end
    end

    function automatic logic [7:0] tb_code(int idx);
        logic [7:0] t [16] = '{8'hBB, 8'hE7, 8'hEB, 8'hED, 8'hEE, 8'hD7, 8'hDB, 8'hDD,
                               8'hDE, 8'hB7, 8'hBD, 8'h7E, 8'h7D, 8'h7B, 8'h77, 8'hBE};
        return t[idx];
    endfunction

    function automatic int key_pos(int idx);
        logic [7:0] c = tb_code(idx);
        int r = 0, l = 0;
        for (int i = 0; i < 4; i++) begin
            if (!c[4+i]) r = i;
            if (!c[i])   l = i;
        end
        return r*4 + l;
    endfunction

    function automatic longint mult_of(int u);
        return (u == 1) ? 64'd1000 : (u == 2) ? 64'd1000000 : 64'd1;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); poll_tick = 1'b1;
        @(negedge clk); poll_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic hold(int idx);
        pressed = '0;
        pressed[key_pos(idx)] = 1'b1;
    endtask

    task automatic press_raw(int idx);
        hold(idx); tick(); tick(); tick();
        pressed = '0; tick(); tick();
        repeat (2) @(negedge clk);
    endtask

    task automatic model_key(int idx);
        if (idx <= 9) begin
            if (m_cnt < MAXD) begin m_val = m_val*10 + idx; m_cnt++; end
        end else if (idx == 11) begin
            m_res = m_val * mult_of(m_unit);
            if (m_res > LIMIT) m_res = 0;
            m_val = 0; m_cnt = 0;
        end else if (idx >= 12 && idx <= 14) begin
            m_unit = idx - 12;
        end
    endtask

    task automatic press_check(int idx);
        int kc0 = key_cnt, rc0 = res_cnt;
        press_raw(idx);
        model_key(idx);
        check(key_cnt == kc0 + 1, "R2 strobe count", key_cnt, kc0 + 1);
        check(last_idx == idx, "R2 index", last_idx, idx);
        if (idx <= 9)
            check(value == m_val[19:0], "R6 value", value, m_val);
        else
            check(value == m_val[19:0], "R7/R8/R9 value", value, m_val);
        check(int'(unit_sel) == m_unit, "R8 unit", unit_sel, m_unit);
        if (idx == 11) begin
            check(res_cnt == rc0 + 1, "R9 result strobe", res_cnt, rc0 + 1);
            check(last_res == m_res, "R9 result", last_res, m_res);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        int unsigned sd;
        int kc;
        sd = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(port_drv == 8'hF0, "R1 drive", port_drv, 8'hF0);
        check(value == 0, "R1 value", value, 0);
        check(unit_sel == 0, "R1 unit", unit_sel, 0);
        check(!key_valid && !result_valid, "R1 strobes", {key_valid, result_valid}, 0);

        // R5 no tick, no action
        hold(3);
        repeat (40) @(negedge clk);
        check(port_drv == 8'hF0, "R5 drive", port_drv, 8'hF0);
        pressed = '0;
        repeat (5) @(negedge clk);
        check(key_cnt == 0, "R5 no key", key_cnt, 0);

        // R2 every key in order (includes digits, units, enter, point, aux)
        for (int i = 0; i < 16; i++) press_check(i);

        // R3 bounce: first and second samples differ
        kc = key_cnt;
        hold(4); tick();
        hold(7); tick();
        pressed = '0; tick(); tick(); tick();
        check(key_cnt == kc, "R3 bounce ignored", key_cnt, kc);
        check(value == m_val[19:0], "R3 value kept", value, m_val);

        // R4 held key and re-press before release confirm
        kc = key_cnt;
        hold(5); tick(); tick();
        repeat (5) tick();
        check(key_cnt == kc, "R4 held key silent", key_cnt, kc);
        pressed = '0; tick();
        hold(5); tick();
        check(key_cnt == kc, "R4 re-press silent", key_cnt, kc);
        pressed = '0; tick(); tick();
        repeat (2) @(negedge clk);
        model_key(5);
        check(key_cnt == kc + 1 && last_idx == 5, "R4 reported after release", last_idx, 5);
        check(value == m_val[19:0], "R4 value", value, m_val);

        // R10 two keys on one row -> unlisted code
        kc = key_cnt;
        pressed = '0; pressed[0*4+0] = 1'b1; pressed[0*4+1] = 1'b1;
        tick(); tick(); tick();
        pressed = '0; tick(); tick();
        repeat (2) @(negedge clk);
        check(key_cnt == kc, "R10 unlisted ignored", key_cnt, kc);
        check(value == m_val[19:0], "R10 value kept", value, m_val);

        // R6 digit cap, Hz
        press_check(11); press_check(12);
        for (int d = 1; d <= 7; d++) press_check(d);
        check(value == 20'd123456, "R6 six digit cap", value, 123456);
        press_check(11);
        check(last_res == 123456, "R9 Hz result", last_res, 123456);

        // R9 boundaries
        press_check(14); press_check(1); press_check(6); press_check(0); press_check(11);
        check(last_res == 160000000, "R9 at limit", last_res, 160000000);
        press_check(13);
        press_check(1); press_check(6); press_check(0); press_check(0); press_check(0); press_check(1);
        press_check(11);
        check(last_res == 0, "R9 above limit", last_res, 0);
        press_check(14);
        for (int d = 0; d < 6; d++) press_check(9);
        press_check(11);
        check(last_res == 0, "R9 far above limit", last_res, 0);
        check(unit_sel == 2, "R9 unit kept", unit_sel, 2);

        // R7 point and aux mid-entry
        press_check(4); press_check(10); press_check(15); press_check(2);
        check(value == 20'd42, "R7 point/aux inert", value, 42);

        // random sequence
        for (int n = 0; n < 150; n++) press_check(int'($urandom % 16));

        done = 1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

endmodule